// File: doc/BRIEF.md
# Region-Dependent Bus Cycle Timer

This block produces the end-of-cycle strobe for a processor bus that runs off a fast master clock. Each bus cycle lasts 6, 8 or 12 master clocks. The length depends on what the coming cycle touches: a pre-decoded region code, the address against a high-ROM threshold, an internal-cycle flag, and a register-written speed bit. The length is latched when a cycle begins and is held until the strobe. An external refresh-stall request freezes the count, and counting resumes from the frozen value when the request drops.

The sequencer has three states. IDLE means no cycle is in progress. RUN means counting. HOLD means frozen by the refresh stall. The transitions are:
- START (IDLE to RUN): a request arrives with no stall.
- CHAIN (RUN or HOLD to RUN): a new request arrives in the cycle's last clock, so the next cycle starts back to back.
- DONE (RUN or HOLD to IDLE): the last clock passes with no request.
- FREEZE (RUN to HOLD): the stall is asserted.
- THAW (HOLD to RUN): the stall drops.

A cycle begins on the clock edge where a request is present, no stall is asserted, and the block is idle or in its last clock.

Top module: `bus_cycle_timer`

## Requirements
- R1: After reset, `cyc_end` is 0, `cyc_len` is 0 and the speed bit is 0, so a high-ROM access takes 8 clocks until the bit is written.
- R2: When `internal_cyc` is 1, the cycle takes 6 clocks whatever the region code and address.
- R3: Region code 0 (ROM) takes 6 clocks when `bus_addr` >= 24'h800000 and the speed bit is 1. Otherwise it takes 8 clocks.
- R4: Region code 1 (work RAM) takes 8 clocks. Code 4 (other) takes 8 clocks. The unused codes 5, 6 and 7 also take 8 clocks.
- R5: Region code 2 (I/O registers) takes 6 clocks.
- R6: Region code 3 (controller serial port) takes 12 clocks.
- R7: A cycle that starts on edge k keeps `cyc_end` high in exactly one clock, the one after edge k+L-1, where L is the cycle length. A request held across that clock starts the next cycle on the following edge, with no gap.
- R8: While `refresh_stall` is 1, `cyc_end` stays 0, the count holds, and no cycle starts. Each stalled clock delays the strobe by one clock.
- R9: The length is sampled only at the start edge. Changes to region, address or flags during a cycle alter neither `cyc_len` nor the strobe time.
- R10: A speed-bit write (`speed_we`=1, value `speed_wd`) acts only on cycles that start after the write edge. A cycle starting on the same edge uses the old value.
- R11: With no request, the block sits in IDLE with `cyc_len` = 0 and issues no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | Address of the coming access |
| acc_valid | input | 1 | A memory access is requested |
| internal_cyc | input | 1 | An internal (no memory) cycle is requested |
| speed_we | input | 1 | Write strobe for the speed bit |
| speed_wd | input | 1 | Value written to the speed bit |
| region | input | 3 | Region code: 0 ROM, 1 work RAM, 2 I/O, 3 serial port, 4 other |
| refresh_stall | input | 1 | Freeze request from the refresh scheduler |
| cyc_end | output | 1 | High in the last master clock of a bus cycle |
| cyc_len | output | 4 | Length of the current cycle, 0 when idle |

## Verification
The bench drives a request in clock c. That cycle then starts on the next edge, and its strobe is due in clock c+L+S, where S counts the stalled clocks that fell inside the cycle or before its start. A back-to-back cycle is due L2 clocks after the first strobe. Each driver call enqueues the expected length and the absolute clock number. The monitor samples at the falling edge and pops one entry per strobe, so a strobe that is early, late, extra or has the wrong length is reported. After each access the bench waits past the strobe and confirms the idle outputs.

// File: rtl/bct_pkg.sv
package bct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } bct_state_e;

    typedef enum logic [2:0] {
        RG_ROM   = 3'd0,
        RG_WRAM  = 3'd1,
        RG_MMIO  = 3'd2,
        RG_PORT  = 3'd3,
        RG_OTHER = 3'd4
    } bct_region_e;
endpackage

// File: rtl/bct_speed_reg.sv
module bct_speed_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wd,
    output logic fast
);
    always_ff @(posedge clk) begin
        if (!rst_n)  fast <= 1'b0;
        else if (we) fast <= wd;
    end

    // R10: the bit changes only on a write
    a_r10_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (fast == $past(fast)));
endmodule

// File: rtl/bct_len_decode.sv
module bct_len_decode
    import bct_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          CNT_W     = 4,
    parameter logic [23:0] FAST_BASE = 24'h800000,
    parameter int          LEN_FAST  = 6,
    parameter int          LEN_SLOW  = 8,
    parameter int          LEN_XSLOW = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              internal_cyc,
    input  logic              fast,
    input  logic [2:0]        region,
    output logic [CNT_W-1:0]  len
);
    localparam logic [CNT_W-1:0] L_F = CNT_W'(LEN_FAST);
    localparam logic [CNT_W-1:0] L_S = CNT_W'(LEN_SLOW);
    localparam logic [CNT_W-1:0] L_X = CNT_W'(LEN_XSLOW);

    logic high_rom;
    assign high_rom = (addr >= ADDR_W'(FAST_BASE));

    always_comb begin
        if (internal_cyc) begin
            len = L_F;
        end else begin
            unique case (region)
                RG_ROM:  len = (high_rom && fast) ? L_F : L_S;
                RG_WRAM: len = L_S;
                RG_MMIO: len = L_F;
                RG_PORT: len = L_X;
                default: len = L_S;
            endcase
        end
    end
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
    import bct_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter logic [23:0] FAST_BASE = 24'h800000,
    parameter int          LEN_FAST  = 6,
    parameter int          LEN_SLOW  = 8,
    parameter int          LEN_XSLOW = 12,
    localparam int         CNT_W     = $clog2(LEN_XSLOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              acc_valid,
    input  logic              internal_cyc,
    input  logic              speed_we,
    input  logic              speed_wd,
    input  logic [2:0]        region,
    input  logic              refresh_stall,
    output logic              cyc_end,
    output logic [CNT_W-1:0]  cyc_len
);
    bct_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len_q, len_d;
    logic [CNT_W-1:0] new_len;
    logic             fast;
    logic             req, active, at_end, start;

    bct_speed_reg u_speed (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (speed_we),
        .wd   (speed_wd),
        .fast (fast)
    );

    bct_len_decode #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .FAST_BASE(FAST_BASE),
        .LEN_FAST (LEN_FAST),
        .LEN_SLOW (LEN_SLOW),
        .LEN_XSLOW(LEN_XSLOW)
    ) u_dec (
        .addr        (bus_addr),
        .internal_cyc(internal_cyc),
        .fast        (fast),
        .region      (region),
        .len         (new_len)
    );

    assign req    = acc_valid | internal_cyc;
    assign active = (state_q != ST_IDLE);
    assign at_end = active && !refresh_stall && (cnt_q == len_q);
    assign start  = req && !refresh_stall && (!active || at_end);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        len_d   = len_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin                 // START
                    state_d = ST_RUN;
                    cnt_d   = CNT_W'(1);
                    len_d   = new_len;
                end
            end
            ST_RUN, ST_HOLD: begin
                if (refresh_stall) begin         // FREEZE / stay frozen
                    state_d = ST_HOLD;
                end else if (at_end) begin
                    if (start) begin             // CHAIN
                        state_d = ST_RUN;
                        cnt_d   = CNT_W'(1);
                        len_d   = new_len;
                    end else begin               // DONE
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                        len_d   = '0;
                    end
                end else begin                   // THAW / keep counting
                    state_d = ST_RUN;
                    cnt_d   = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
                len_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        cyc_end = at_end;
        cyc_len = active ? len_q : '0;
    end

    // R8: no strobe while stalled
    a_r8_no_end_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stall |-> !cyc_end);
    // R8: count frozen across a stalled clock
    a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (active && refresh_stall) |=> (cnt_q == $past(cnt_q)));
    // R9: length held within a cycle
    a_r9_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cyc_end) |=> (cyc_len == $past(cyc_len)));
    // R7: count stays inside the latched length
    a_r7_cnt_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q >= CNT_W'(1) && cnt_q <= len_q));
    // R11: strobe with no request leaves the block idle
    a_r11_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !req) |=> (cyc_len == '0 && !cyc_end));
endmodule

// File: tb/tb_bus_cycle_timer.sv
module tb_bus_cycle_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        acc_valid = 1'b0;
    logic        internal_cyc = 1'b0;
    logic        speed_we = 1'b0;
    logic        speed_wd = 1'b0;
    logic [2:0]  region = '0;
    logic        refresh_stall = 1'b0;
    logic        cyc_end;
    logic [3:0]  cyc_len;

    int     checks = 0;
    int     errors = 0;
    longint cyc_n = 0;
    bit     done = 1'b0;

    typedef struct {
        int     len;
        longint at;
        string  req;
    } exp_t;
    exp_t q[$];

    bus_cycle_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .acc_valid(acc_valid),
        .internal_cyc(internal_cyc), .speed_we(speed_we), .speed_wd(speed_wd),
        .region(region), .refresh_stall(refresh_stall),
        .cyc_end(cyc_end), .cyc_len(cyc_len)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && cyc_end) begin
            if (q.size() == 0) begin
                check(1'b0, "R11", "unexpected strobe at clock", cyc_n, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc_len == 4'(e.len), e.req, "cycle length", cyc_len, e.len);
                check(cyc_n == e.at, e.req, "strobe clock", cyc_n, e.at);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic idle_check(input string req);
        check(cyc_len == 4'd0 && !cyc_end, req, "idle cyc_len", cyc_len, 0);
    endtask

    // single access; optional same-edge speed write; optional stall inside the cycle
    task automatic access(input logic [2:0] rg, input logic [23:0] a, input logic intl,
                          input logic wr, input int sa, input int sn,
                          input int exp_len, input string req);
        longint c;
        exp_t   e;
        step();
        c = cyc_n;
        region = rg; bus_addr = a; internal_cyc = intl; acc_valid = !intl;
        if (wr) begin speed_we = 1'b1; speed_wd = 1'b1; end
        e.len = exp_len; e.at = c + exp_len + sn; e.req = req;
        q.push_back(e);
        step();
        acc_valid = 1'b0; internal_cyc = 1'b0; speed_we = 1'b0;
        region = 3'd3; bus_addr = ~a;                // R9: inputs move mid-cycle
        if (sn > 0) begin
            repeat (sa) step();
            refresh_stall = 1'b1;
            repeat (sn) step();
            refresh_stall = 1'b0;
        end
        repeat (exp_len + 2) step();
        idle_check("R11");
    endtask

    // request raised together with a stall while idle
    task automatic idle_stall(input logic [2:0] rg, input int k, input int exp_len);
        longint c;
        exp_t   e;
        step();
        c = cyc_n;
        region = rg; bus_addr = 24'h001000; acc_valid = 1'b1; refresh_stall = 1'b1;
        e.len = exp_len; e.at = c + k + exp_len; e.req = "R8";
        q.push_back(e);
        repeat (k) step();
        refresh_stall = 1'b0;
        check(cyc_len == 4'd0, "R8", "no start while stalled", cyc_len, 0);
        step();
        acc_valid = 1'b0;
        repeat (exp_len + 2) step();
        idle_check("R11");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog", "run timed out", cyc_n, 0);
        finish_up();
    end

    initial begin
        repeat (3) step();
        check(cyc_end == 1'b0, "R1", "reset cyc_end", cyc_end, 0);
        check(cyc_len == 4'd0, "R1", "reset cyc_len", cyc_len, 0);
        rst_n = 1'b1;
        repeat (3) step();
        idle_check("R11");

        // R1/R3: speed bit resets to 0 -> high ROM is 8
        access(3'd0, 24'hC00000, 1'b0, 1'b0, 0, 0, 8, "R1");
        // R10: write on the start edge, old value applies
        access(3'd0, 24'h800000, 1'b0, 1'b1, 0, 0, 8, "R10");
        // R10/R3: new value from the next cycle
        access(3'd0, 24'h800000, 1'b0, 1'b0, 0, 0, 6, "R10");
        // R3: below threshold stays slow
        access(3'd0, 24'h7FFFFF, 1'b0, 1'b0, 0, 0, 8, "R3");
        access(3'd0, 24'hFFFFFF, 1'b0, 1'b0, 0, 0, 6, "R3");
        // R4
        access(3'd1, 24'h7E0000, 1'b0, 1'b0, 0, 0, 8, "R4");
        access(3'd4, 24'h900000, 1'b0, 1'b0, 0, 0, 8, "R4");
        access(3'd6, 24'h900000, 1'b0, 1'b0, 0, 0, 8, "R4");
        // R5, R6
        access(3'd2, 24'h002100, 1'b0, 1'b0, 0, 0, 6, "R5");
        access(3'd3, 24'h004016, 1'b0, 1'b0, 0, 0, 12, "R6");
        // R2: internal beats the slowest region
        access(3'd3, 24'h004017, 1'b1, 1'b0, 0, 0, 6, "R2");
        // R8: stall mid-cycle and over the last clock
        access(3'd3, 24'h004016, 1'b0, 1'b0, 2, 5, 12, "R8");
        access(3'd3, 24'h004016, 1'b0, 1'b0, 9, 3, 12, "R8");
        idle_stall(3'd2, 3, 6);

        // R7/R9: back-to-back, inputs changed during the first cycle
        begin
            longint c;
            exp_t   e;
            step();
            c = cyc_n;
            region = 3'd1; bus_addr = 24'h7E0010; acc_valid = 1'b1;
            e.len = 8;  e.at = c + 8;      e.req = "R7"; q.push_back(e);
            e.len = 12; e.at = c + 8 + 12; e.req = "R9"; q.push_back(e);
            step();
            region = 3'd3; bus_addr = 24'h004016;
            repeat (8) step();
            acc_valid = 1'b0;
            repeat (16) step();
            idle_check("R11");
        end

        repeat (10) step();
        check(q.size() == 0, "R7", "strobes still owed", q.size(), 0);
        idle_check("R11");
        finish_up();
    end
endmodule